// File: doc/BRIEF.md
# Moore Serial Adder

This block adds two binary operands that arrive one bit pair per clock, least significant bit first. On each rising edge it takes the present bit pair and the carry it kept from the previous pair. It then moves to one of four states, and each state stands for a combination of a carry value and a sum bit. The output is decoded from the registered state alone, so each sum bit shows up one clock after the operand bits that produced it.

A synchronous, active-high clear puts the machine back in the state that holds no carry and a zero sum bit. The surrounding logic raises the clear between words. To collect the final carry of a word, the user shifts in one extra pair of zeros after the last operand bits. The state code is a parameter: either a plain carry/sum pair or a Gray ordering of the four states. Both codes use two flip-flops.

Top module: `moore_serial_adder`

## Requirements
- R1: When `clr` is high at a rising edge, the machine enters the cleared state, whatever `a_bit` and `b_bit` are. After that edge `sum_q` is 0. The stored carry is also 0, so a following pair of zeros yields `sum_q` 0.
- R2: When `clr` is low at a rising edge, `sum_q` after that edge equals `a_bit` XOR `b_bit` XOR the stored carry.
- R3: When `clr` is low at a rising edge, the stored carry becomes the majority of `a_bit`, `b_bit` and the old carry. A following pair of zeros therefore shows that carry on `sum_q`.
- R4: `sum_q` changes only at rising edges. Changes on `a_bit` or `b_bit` between edges leave it unchanged.
- R5: Apply a clear, then the bits of two 8-bit operands least significant first, then one pair of zeros. The nine `sum_q` values seen after those nine edges, first value as bit 0, equal the arithmetic sum of the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high |
| a_bit | input | 1 | Serial bit of operand A, least significant first |
| b_bit | input | 1 | Serial bit of operand B, least significant first |
| sum_q | output | 1 | Registered sum bit, one clock behind its operand bits |

## Verification
A wrong sum bit stored in the state shows on `sum_q` right after the edge that wrote it, one clock after the bad operand pair. A wrong stored carry stays hidden for that cycle. It appears only at the next edge, as a flipped sum bit, so a check must follow each carry-producing pair with a known pair, such as zeros, to expose it within two clocks. A clear that fails to drop the carry shows up in the same way on the first pair after the clear.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

   // Logical view of the machine: stored carry and present sum bit.
   typedef struct packed {
      logic carry;
      logic sum;
   } sadd_state_t;

   // Code selection for the two state flip-flops.
   localparam int SADD_MAP_PLAIN = 0;   // code = {carry, sum}
   localparam int SADD_MAP_GRAY  = 1;   // code = Gray order S0,S1,S2,S3
   localparam int SADD_CODE_W    = 2;

   // Cleared state: no carry, zero sum, code 00 in both maps.
   localparam logic [SADD_CODE_W-1:0] SADD_CLR_CODE = '0;

endpackage

// File: rtl/sadd_next.sv
// Next logical state: {carry, sum} of a + b + stored carry.
module sadd_next
   import sadd_pkg::*;
(
   input  logic        a_bit,
   input  logic        b_bit,
   input  sadd_state_t cur,
   output sadd_state_t nxt
);

   logic gen_c;
   logic prop_c;

   always_comb begin
      gen_c     = a_bit & b_bit;
      prop_c    = a_bit ^ b_bit;
      nxt.sum   = prop_c ^ cur.carry;
      nxt.carry = gen_c | (prop_c & cur.carry);
   end

endmodule

// File: rtl/sadd_code.sv
// Maps logical state to flip-flop code and back, per the chosen map.
module sadd_code
   import sadd_pkg::*;
#(
   parameter int STATE_MAP = SADD_MAP_PLAIN,
   parameter int CODE_W    = SADD_CODE_W
) (
   input  sadd_state_t       log_in,
   output logic [CODE_W-1:0] code_out,
   input  logic [CODE_W-1:0] code_in,
   output sadd_state_t       log_out
);

   generate
      if (CODE_W != 2) begin : g_bad_width
         $error("sadd_code: CODE_W must be 2");
      end

      if (STATE_MAP == SADD_MAP_PLAIN) begin : g_plain
         always_comb begin
            code_out      = {log_in.carry, log_in.sum};
            log_out.carry = code_in[1];
            log_out.sum   = code_in[0];
         end
      end else if (STATE_MAP == SADD_MAP_GRAY) begin : g_gray
         // S0=00, S1=01, S2=11, S3=10
         always_comb begin
            code_out      = {log_in.carry, log_in.carry ^ log_in.sum};
            log_out.carry = code_in[1];
            log_out.sum   = code_in[1] ^ code_in[0];
         end
      end else begin : g_bad_map
         $error("sadd_code: unsupported STATE_MAP");
         always_comb begin
            code_out = '0;
            log_out  = '0;
         end
      end
   endgenerate

endmodule

// File: rtl/sadd_state_reg.sv
// State flip-flops with synchronous active-high clear.
module sadd_state_reg #(
   parameter int              W        = 2,
   parameter logic [W-1:0]    CLR_CODE = '0
) (
   input  logic         clk,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (clr) q <= CLR_CODE;
      else     q <= d;
   end

endmodule

// File: rtl/moore_serial_adder.sv
module moore_serial_adder
   import sadd_pkg::*;
#(
   parameter int STATE_MAP = SADD_MAP_PLAIN
) (
   input  logic clk,
   input  logic clr,
   input  logic a_bit,
   input  logic b_bit,
   output logic sum_q
);

   localparam int CW = SADD_CODE_W;

   logic [CW-1:0] code_q;
   logic [CW-1:0] code_d;
   sadd_state_t   cur_st;
   sadd_state_t   nxt_st;
   logic          carry_q;

   sadd_code #(.STATE_MAP(STATE_MAP), .CODE_W(CW)) u_code (
      .log_in  (nxt_st),
      .code_out(code_d),
      .code_in (code_q),
      .log_out (cur_st)
   );

   sadd_next u_next (
      .a_bit(a_bit),
      .b_bit(b_bit),
      .cur  (cur_st),
      .nxt  (nxt_st)
   );

   sadd_state_reg #(.W(CW), .CLR_CODE(SADD_CLR_CODE)) u_reg (
      .clk(clk),
      .clr(clr),
      .d  (code_d),
      .q  (code_q)
   );

   // Moore output: present state only.
   assign sum_q   = cur_st.sum;
   assign carry_q = cur_st.carry;

endmodule

// File: rtl/sadd_chk.sv
module sadd_chk (
   input logic clk,
   input logic clr,
   input logic a_bit,
   input logic b_bit,
   input logic sum_q,
   input logic carry_q
);

   AST_CLEAR_STATE: assert property (@(posedge clk)
      clr |=> (clr || (!sum_q && !carry_q)));                                   // R1

   AST_SUM_BIT: assert property (@(posedge clk) disable iff (clr)
      !clr |=> sum_q == ($past(a_bit) ^ $past(b_bit) ^ $past(carry_q)));        // R2

   AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (clr)
      !clr |=> carry_q == (($past(a_bit) & $past(b_bit)) |
                           (($past(a_bit) ^ $past(b_bit)) & $past(carry_q))));  // R3

   AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (clr)
      (!a_bit && !b_bit) |=> (!carry_q && sum_q == $past(carry_q)));            // R3

   AST_NO_X_OUT: assert property (@(posedge clk) disable iff (clr)
      !$isunknown(sum_q));                                                      // R2

endmodule

bind moore_serial_adder sadd_chk u_chk (
   .clk    (clk),
   .clr    (clr),
   .a_bit  (a_bit),
   .b_bit  (b_bit),
   .sum_q  (sum_q),
   .carry_q(carry_q)
);

// File: tb/tb_moore_serial_adder.sv
`timescale 1ns/1ps
module tb_moore_serial_adder;

   logic clk = 1'b0;
   logic clr = 1'b1;
   logic a_bit = 1'b0;
   logic b_bit = 1'b0;
   logic sum_q;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   moore_serial_adder dut (
      .clk  (clk),
      .clr  (clr),
      .a_bit(a_bit),
      .b_bit(b_bit),
      .sum_q(sum_q)
   );

   task automatic check(input string req, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: sum_q=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   // Drive one pair at the falling edge, let one rising edge pass, settle.
   task automatic step(input logic c, input logic a, input logic b);
      @(negedge clk);
      clr   = c;
      a_bit = a;
      b_bit = b;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      step(1'b1, 1'b1, 1'b1);
      check("R1 reset state", sum_q, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      check("R1 no carry after reset", sum_q, 1'b0);
   endtask

   task automatic t_pairs();
      for (int cin = 0; cin < 2; cin++) begin
         for (int p = 0; p < 4; p++) begin
            logic a, b, s, co;
            a  = p[1];
            b  = p[0];
            s  = a ^ b ^ cin[0];
            co = (a & b) | ((a ^ b) & cin[0]);
            step(1'b1, 1'b0, 1'b0);
            if (cin == 1) step(1'b0, 1'b1, 1'b1);
            step(1'b0, a, b);
            check("R2 sum bit", sum_q, s);
            step(1'b0, 1'b0, 1'b0);
            check("R3 carry out", sum_q, co);
         end
      end
   endtask

   task automatic t_clear_mid();
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b1);          // carry now 1
      step(1'b1, 1'b1, 1'b1);          // clear wins over inputs
      check("R1 clear ignores inputs", sum_q, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      check("R1 clear drops carry", sum_q, 1'b0);
   endtask

   task automatic t_hold();
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      check("R4 sum before hold", sum_q, 1'b1);
      @(negedge clk);
      a_bit = 1'b1; b_bit = 1'b1;
      #2;
      check("R4 hold after input change", sum_q, 1'b1);
      a_bit = 1'b0; b_bit = 1'b0;
      #1;
      check("R4 hold after second change", sum_q, 1'b1);
   endtask

   task automatic t_words(input int n);
      for (int w = 0; w < n; w++) begin
         logic [7:0] x, y;
         logic [8:0] got, exp;
         x = 8'($urandom);
         y = 8'($urandom);
         if (w == 0) begin x = 8'hFF; y = 8'h01; end
         if (w == 1) begin x = 8'hFF; y = 8'hFF; end
         if (w == 2) begin x = 8'h00; y = 8'h00; end
         exp = {1'b0, x} + {1'b0, y};
         step(1'b1, 1'b0, 1'b0);
         for (int i = 0; i < 8; i++) begin
            step(1'b0, x[i], y[i]);
            got[i] = sum_q;
         end
         step(1'b0, 1'b0, 1'b0);
         got[8] = sum_q;
         total++;
         if (got !== exp) begin
            bad++;
            $display("FAIL R5 word %0h+%0h: sum=%0h expected=%0h", x, y, got, exp);
         end
      end
   endtask

   initial begin
      #200000000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run hung, actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_pairs();
      t_clear_mid();
      t_hold();
      t_words(40);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule